// File: doc/BRIEF.md
# Successive Approximation Code Search

This block tunes an 8-bit control code by binary search, as a frequency-locked loop does when it trims an oscillator. A separate counter measures the oscillator and delivers a 9-bit cycle count together with a one-cycle valid strobe. On each strobe the block compares that count with a 9-bit target and decides one bit of the code. The search runs from the most significant bit down, so eight strobes give a complete code.

A one-hot trial mask marks the bit under test. If the measured count is below the target, the tested bit stays set. If it is not below, the tested bit is cleared. In both cases the next lower bit is set as the new trial and the mask moves one place right. The code is never counted up or down, so it cannot wrap.

After the decision on bit 0 the mask empties and the done flag rises. The code then holds until the search is restarted by taking enable low and high again.

Top module: `sar_code_search`

## Requirements
- R1: While rst_n is low, and after it is released, the outputs are code = 8'h80, trial_mask = 8'h80 and done = 0.
- R2: A search step is a cycle in which meas_valid is high, enable is high, enable was also high in the previous cycle, and done is 0. In a step where meas_count < target_count (unsigned), code becomes code | (trial_mask >> 1) one clock later.
- R3: In a step where meas_count >= target_count, the bit of code under trial_mask is cleared and the bit under (trial_mask >> 1) is set, one clock later.
- R4: Every step moves trial_mask exactly one position toward bit 0. trial_mask is always one-hot or zero. In a cycle that is not a step, code and trial_mask keep their values.
- R5: A step taken with trial_mask = 8'h01 only keeps or clears bit 0 of code. trial_mask then becomes 8'h00 and done becomes 1.
- R6: While done is 1, strobes change neither code nor trial_mask.
- R7: While enable is low, code, trial_mask and done hold and strobes are ignored.
- R8: In the first cycle in which enable is high after being low, the search restarts: one clock later code = 8'h80, trial_mask = 8'h80 and done = 0. A strobe in that same cycle is ignored.
- R9: The comparison uses all 9 bits, so a target of 256 or more is honoured. The final code equals the eight decisions, most significant bit first (1 = below target). This lets 8'hFF and 8'h00 be reached without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Search enable; a rising level restarts the search |
| meas_valid | input | 1 | One-cycle strobe marking a fresh measured count |
| meas_count | input | 9 | Measured cycle count |
| target_count | input | 9 | Target cycle count |
| code | output | 8 | Control code under search |
| trial_mask | output | 8 | One-hot mask of the bit under trial |
| done | output | 1 | Search finished |

## Verification
Every result is registered once. A step, a restart or the final decision shows on code, trial_mask and done exactly one clock after the cycle in which the bench presents it. The bench drives each input on a falling edge, holds it through one rising edge, and compares the outputs on the next falling edge. After ignored stimuli (enable low, strobes after done, and a strobe in the restart cycle), the bench checks at that same falling edge that the outputs have not changed.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_RESTART = 2'd1,
    ACT_STEP    = 2'd2
  } sar_act_e;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     meas_valid,
  input  logic     done_i,
  output sar_act_e act
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end

  always_comb begin
    act = ACT_HOLD;
    if (enable && !en_q)                      act = ACT_RESTART;
    else if (enable && meas_valid && !done_i) act = ACT_STEP;
  end

  // R6: a finished search never takes a step
  assert_no_step_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> act != ACT_STEP);
  // R7: nothing but hold while disabled
  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> act == ACT_HOLD);
endmodule

// File: rtl/sar_step.sv
module sar_step #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 9
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] mask_i,
  input  logic [CNT_W-1:0]  meas_i,
  input  logic [CNT_W-1:0]  target_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] mask_o,
  output logic              last_o
);
  logic              below;
  logic [CODE_W-1:0] next_trial;

  assign below      = meas_i < target_i;
  assign next_trial = mask_i >> 1;
  assign last_o     = mask_i[0];

  always_comb begin
    if (below) code_o = code_i | next_trial;
    else       code_o = (code_i & ~mask_i) | next_trial;
    mask_o = next_trial;
  end
endmodule

// File: rtl/sar_code_search.sv
module sar_code_search
  import sar_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              meas_valid,
  input  logic [CNT_W-1:0]  meas_count,
  input  logic [CNT_W-1:0]  target_count,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] trial_mask,
  output logic              done
);
  localparam logic [CODE_W-1:0] INIT_VAL = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] LSB_ONLY = {{(CODE_W-1){1'b0}}, 1'b1};

  logic [CODE_W-1:0] code_q, mask_q, code_d, mask_d, step_code, step_mask;
  logic              done_q, done_d, step_last, load;
  sar_act_e          act;

  sar_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .meas_valid(meas_valid),
    .done_i(done_q), .act(act)
  );

  sar_step #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_step (
    .code_i(code_q), .mask_i(mask_q), .meas_i(meas_count), .target_i(target_count),
    .code_o(step_code), .mask_o(step_mask), .last_o(step_last)
  );

  always_comb begin
    load   = 1'b0;
    code_d = code_q;
    mask_d = mask_q;
    done_d = done_q;
    case (act)
      ACT_RESTART: begin
        load = 1'b1; code_d = INIT_VAL; mask_d = INIT_VAL; done_d = 1'b0;
      end
      ACT_STEP: begin
        load = 1'b1; code_d = step_code; mask_d = step_mask; done_d = step_last;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= INIT_VAL;
      mask_q <= INIT_VAL;
      done_q <= 1'b0;
    end else if (load) begin
      code_q <= code_d;
      mask_q <= mask_d;
      done_q <= done_d;
    end
  end

  assign code       = code_q;
  assign trial_mask = mask_q;
  assign done       = done_q;

  // R4: the trial mask never holds more than one bit
  assert_mask_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));
  // R4: each step walks the mask one position
  assert_mask_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_STEP |=> mask_q == ($past(mask_q) >> 1));
  // R5: the bit-0 decision ends the search
  assert_final_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP && mask_q == LSB_ONLY) |=> (done_q && mask_q == '0));
  // R6: a finished code is frozen until restart
  assert_done_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && act != ACT_RESTART) |=> $stable(code_q));
  // R7: disabled means held
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(code_q) && $stable(mask_q) && $stable(done_q)));
  // R8: restart reloads the start point
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_RESTART |=> (code_q == INIT_VAL && mask_q == INIT_VAL && !done_q));
endmodule

// File: tb/sim_sar_code_search.sv
`timescale 1ns/100ps
module sim_sar_code_search;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic       meas_valid;
  logic [8:0] meas_count;
  logic [8:0] target_count;
  logic [7:0] code;
  logic [7:0] trial_mask;
  logic       done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  // Decision patterns (1 = below target, MSB decided first) and targets
  localparam int NV = 6;
  localparam logic [7:0] DEC_TAB [NV] = '{8'hFF, 8'h00, 8'hA5, 8'h5A, 8'h80, 8'h01};
  localparam logic [8:0] TGT_TAB [NV] = '{9'd256, 9'd1, 9'd100, 9'd511, 9'd2, 9'd300};

  always #2.5 clk = ~clk;

  sar_code_search u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .meas_valid(meas_valid),
    .meas_count(meas_count), .target_count(target_count),
    .code(code), .trial_mask(trial_mask), .done(done)
  );

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {code,mask,done}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input logic [7:0] c, input logic [7:0] m, input logic d);
    check(req, {code, trial_mask, done}, {c, m, d});
  endtask

  task automatic restart();
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    expect_out("R8 restart", 8'h80, 8'h80, 1'b0);
  endtask

  task automatic strobe(input bit below, input logic [8:0] tgt);
    target_count = tgt;
    meas_count   = below ? tgt - 9'd1 : tgt;
    meas_valid   = 1'b1;
    @(negedge clk);
    meas_valid   = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; meas_valid = 1'b0;
    meas_count = '0; target_count = '0;
    repeat (3) @(negedge clk);
    expect_out("R1 in reset", 8'h80, 8'h80, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 after reset", 8'h80, 8'h80, 1'b0);

    // Table-driven searches: R2, R3, R4, R5, R9
    for (int v = 0; v < NV; v++) begin
      restart();
      for (int p = 7; p >= 0; p--) begin
        logic [7:0] hi, ec, em;
        strobe(DEC_TAB[v][p], TGT_TAB[v]);
        hi = DEC_TAB[v] & (8'hFF << p);
        ec = (p > 0) ? (hi | (8'h01 << (p - 1))) : DEC_TAB[v];
        em = (p > 0) ? (8'h01 << (p - 1)) : 8'h00;
        if (p > 0) expect_out(DEC_TAB[v][p] ? "R2 below step" : "R3 not-below step", ec, em, 1'b0);
        else       expect_out("R5/R9 final code", ec, em, 1'b1);
      end
      // R6: strobe after done changes nothing
      strobe(!DEC_TAB[v][0], TGT_TAB[v]);
      expect_out("R6 ignored after done", DEC_TAB[v], 8'h00, 1'b1);
    end

    // R4: idle cycle without strobe holds
    restart();
    strobe(1'b1, 9'd50);
    @(negedge clk);
    expect_out("R4 no strobe holds", 8'hC0, 8'h40, 1'b0);

    // R7: strobes with enable low are ignored
    enable = 1'b0;
    strobe(1'b0, 9'd50);
    strobe(1'b1, 9'd50);
    expect_out("R7 disabled hold", 8'hC0, 8'h40, 1'b0);

    // R8: strobe in the restart cycle is ignored
    enable = 1'b1;
    strobe(1'b1, 9'd50);
    expect_out("R8 strobe in restart cycle", 8'h80, 8'h80, 1'b0);
    strobe(1'b0, 9'd50);
    expect_out("R3 after restart", 8'h40, 8'h40, 1'b0);

    // R1: reset mid-search
    strobe(1'b1, 9'd50);
    #1 rst_n = 1'b0;
    @(negedge clk);
    expect_out("R1 reset mid-search", 8'h80, 8'h80, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule